// File: doc/BRIEF.md
# Dual-Mode Shared-Table Logic Cell

This block is one configurable logic cell that owns two equal-sized lookup tables. A mode bit chooses what the pair does, and the cell captures that bit while reset is held. In clocked mode, each table is its own small LUT. The upper table is addressed by the `rail_t_i` wires and the lower table by the `rail_f_i` wires. Both results are registered on the rising clock edge, so each input wire pair carries two independent single-rail bits.

In dual-rail mode, each input bit arrives on a (true, false) wire pair. The two tables then produce the two rails of a single logical output. The true rail comes from the upper table. The false rail comes from the lower table, which the cell internally fills with the bitwise complement of the upper table's contents. The output stays at the spacer code (0,0) in three cases: while precharge is high, until every input pair carries a valid code word, and whenever any pair is illegal. An illegal pair raises an error flag.

Nothing in either mode goes unused, so the same table storage serves both mode bits. The cell has no valid/ready handshake and no back-pressure. In clocked mode a new result is produced on every edge. In dual-rail mode the arrival of a code word and the return to spacer act as the flow control.

Top module: `dlc_cell`

## Requirements
- R1: The mode bit is captured on every rising edge while `rst_n` is low, with 0 meaning clocked and 1 meaning dual-rail. Changing `mode_cfg_i` while `rst_n` is high has no effect on behaviour.
- R2: In clocked mode, one edge after the inputs are sampled, `out_hi_o` equals bit A of `cfg_hi_i`. A is the unsigned number whose bit k is `rail_t_i[k]`.
- R3: In clocked mode, one edge after sampling, `out_lo_o` equals bit B of `cfg_lo_i`. B is the unsigned number whose bit k is `rail_f_i[k]`.
- R4: In clocked mode, `precharge_i` has no effect on the outputs and `err_o` stays 0.
- R5: A rising edge with `rst_n` low and clocked mode selected clears both outputs to 0 for the following cycle.
- R6: In dual-rail mode, precharge low and every pair valid produce a result in the same cycle. A valid pair is (1,0) for logic 1 or (0,1) for logic 0. The output (`out_hi_o`, `out_lo_o`) is (1,0) when bit A of `cfg_hi_i` is 1 and (0,1) when it is 0, with A formed from the true rails as in R2.
- R7: In dual-rail mode, while `precharge_i` is high both outputs are 0 (the spacer).
- R8: In dual-rail mode, if any input pair is (0,0) both outputs are 0.
- R9: In dual-rail mode, any input pair of (1,1) drives `err_o` high in the same cycle and holds both outputs at 0. Without such a pair `err_o` is 0.
- R10: In dual-rail mode, `cfg_lo_i` has no effect and the output pair is never (1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the result registers and mode capture |
| rst_n | input | 1 | Synchronous active-low reset; the mode is captured while it is low |
| mode_cfg_i | input | 1 | Mode select: 0 clocked, 1 dual-rail |
| cfg_hi_i | input | 2**NUM_IN | Upper table contents |
| cfg_lo_i | input | 2**NUM_IN | Lower table contents (clocked mode only) |
| rail_t_i | input | NUM_IN | True rails, or upper-table address in clocked mode |
| rail_f_i | input | NUM_IN | False rails, or lower-table address in clocked mode |
| precharge_i | input | 1 | Forces the spacer in dual-rail mode |
| out_hi_o | output | 1 | Registered upper result, or true rail |
| out_lo_o | output | 1 | Registered lower result, or false rail |
| err_o | output | 1 | An illegal (1,1) input pair is present in dual-rail mode |

## Verification
Clocked-mode results are due one rising edge after the inputs are sampled. Dual-rail results and the error flag follow the inputs within the same cycle. The bench therefore changes inputs one time unit after a rising edge. It advances a behavioural model on that rising edge and compares every output at the following falling edge. By then a registered value has been loaded and the combinational rails have settled, so both latencies are checked on every clock.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

  typedef enum logic {
    MODE_CLOCKED = 1'b0,
    MODE_RAIL    = 1'b1
  } cell_mode_e;

endpackage

// File: rtl/dlc_table.sv
// Lookup table read as a binary mux tree; leaf j holds content bit j,
// tree level d (root = 0) steers with address bit NUM_IN-1-d.
module dlc_table #(
  parameter int unsigned NUM_IN = 2
) (
  input  logic [(1<<NUM_IN)-1:0] content_i,
  input  logic [NUM_IN-1:0]      sel_i,
  output logic                   bit_o
);

  localparam int unsigned LEAVES = 1 << NUM_IN;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic [NODES-1:0] node;

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    assign node[LEAVES-1+j] = content_i[j];
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_inner
    localparam int DEPTH = $clog2(k + 2) - 1;
    assign node[k] = sel_i[NUM_IN-1-DEPTH] ? node[2*k+2] : node[2*k+1];
  end

  assign bit_o = node[0];

endmodule

// File: rtl/dlc_rail_monitor.sv
// Per-pair code-word classification for dual-rail inputs.
module dlc_rail_monitor #(
  parameter int unsigned NUM_IN = 2
) (
  input  logic [NUM_IN-1:0] rail_t_i,
  input  logic [NUM_IN-1:0] rail_f_i,
  output logic              all_valid_o,
  output logic              any_illegal_o
);

  logic [NUM_IN-1:0] pair_valid;
  logic [NUM_IN-1:0] pair_bad;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_pair
    assign pair_valid[i] = rail_t_i[i] ^ rail_f_i[i];
    assign pair_bad[i]   = rail_t_i[i] & rail_f_i[i];
  end

  assign all_valid_o   = &pair_valid;
  assign any_illegal_o = |pair_bad;

endmodule

// File: rtl/dlc_bit_regs.sv
// Result registers: load when enabled, otherwise held cleared.
module dlc_bit_regs #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
    else             q_o <= '0;
  end

endmodule

// File: rtl/dlc_cell.sv
module dlc_cell
  import dlc_pkg::*;
#(
  parameter int unsigned NUM_IN = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_cfg_i,
  input  logic [(1<<NUM_IN)-1:0] cfg_hi_i,
  input  logic [(1<<NUM_IN)-1:0] cfg_lo_i,
  input  logic [NUM_IN-1:0]      rail_t_i,
  input  logic [NUM_IN-1:0]      rail_f_i,
  input  logic                   precharge_i,
  output logic                   out_hi_o,
  output logic                   out_lo_o,
  output logic                   err_o
);

  localparam int unsigned TBL = 1 << NUM_IN;

  // Mode is configuration: loaded only while reset is held.
  cell_mode_e mode_q;
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= cell_mode_e'(mode_cfg_i);
  end

  logic rail_mode;
  assign rail_mode = (mode_q == MODE_RAIL);

  // Lower table: own contents and address in clocked mode; complement of
  // the upper contents under the true-rail address in dual-rail mode.
  logic [TBL-1:0]    lo_content;
  logic [NUM_IN-1:0] lo_sel;
  assign lo_content = rail_mode ? ~cfg_hi_i : cfg_lo_i;
  assign lo_sel     = rail_mode ? rail_t_i  : rail_f_i;

  logic hi_bit, lo_bit;

  dlc_table #(.NUM_IN(NUM_IN)) u_tbl_hi (
    .content_i (cfg_hi_i),
    .sel_i     (rail_t_i),
    .bit_o     (hi_bit)
  );

  dlc_table #(.NUM_IN(NUM_IN)) u_tbl_lo (
    .content_i (lo_content),
    .sel_i     (lo_sel),
    .bit_o     (lo_bit)
  );

  logic all_valid, any_illegal;

  dlc_rail_monitor #(.NUM_IN(NUM_IN)) u_mon (
    .rail_t_i      (rail_t_i),
    .rail_f_i      (rail_f_i),
    .all_valid_o   (all_valid),
    .any_illegal_o (any_illegal)
  );

  logic [1:0] reg_q;

  dlc_bit_regs #(.W(2)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (!rail_mode),
    .d_i    ({hi_bit, lo_bit}),
    .q_o    (reg_q)
  );

  logic eval_ok;
  assign eval_ok = all_valid & ~precharge_i;

  assign out_hi_o = rail_mode ? (eval_ok & hi_bit) : reg_q[1];
  assign out_lo_o = rail_mode ? (eval_ok & lo_bit) : reg_q[0];
  assign err_o    = rail_mode & any_illegal;

  // ---------------------------------------------------------------- checks
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));

  p_sync_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CLOCKED) |=> (out_hi_o == $past(cfg_hi_i[rail_t_i])));

  p_sync_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CLOCKED) |=> (out_lo_o == $past(cfg_lo_i[rail_f_i])));

  p_sync_noerr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CLOCKED) |-> !err_o);

  p_reset_clear_r5: assert property (@(posedge clk)
    (!rst_n && !mode_cfg_i) |=> (!out_hi_o && !out_lo_o));

  p_pre_spacer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_mode && precharge_i) |-> (!out_hi_o && !out_lo_o));

  p_incomplete_spacer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_mode && !all_valid) |-> (!out_hi_o && !out_lo_o));

  p_err_spacer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!out_hi_o && !out_lo_o));

  p_no_double_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rail_mode |-> !(out_hi_o && out_lo_o));

endmodule

// File: tb/dlc_cell_tb_top.sv
module dlc_cell_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 2;
  localparam int T          = 1 << N;
  localparam int WDOG       = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_cfg = 1'b0;
  logic [T-1:0] cfg_hi = '0;
  logic [T-1:0] cfg_lo = '0;
  logic [N-1:0] rail_t = '0;
  logic [N-1:0] rail_f = '0;
  logic         pre = 1'b0;
  logic         out_hi, out_lo, err;

  int    checks = 0;
  int    failures = 0;
  bit    armed = 1'b0;
  bit    done = 1'b0;
  string note = "";

  // behavioural model state
  bit m_mode = 1'b0;
  bit m_hi = 1'b0;
  bit m_lo = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dlc_cell #(.NUM_IN(N)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_cfg_i  (mode_cfg),
    .cfg_hi_i    (cfg_hi),
    .cfg_lo_i    (cfg_lo),
    .rail_t_i    (rail_t),
    .rail_f_i    (rail_f),
    .precharge_i (pre),
    .out_hi_o    (out_hi),
    .out_lo_o    (out_lo),
    .err_o       (err)
  );

  task automatic chk(input string tag, input string what, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b %s t=%0t", tag, what, act, exp, note, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // model advances on the rising edge (inputs are stable there)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = mode_cfg;
      m_hi   = 1'b0;
      m_lo   = 1'b0;
    end else if (!m_mode) begin
      m_hi = cfg_hi[int'(rail_t)];
      m_lo = cfg_lo[int'(rail_f)];
    end else begin
      m_hi = 1'b0;
      m_lo = 1'b0;
    end
    armed = 1'b1;
  end

  // compare on the falling edge
  always @(negedge clk) begin
    if (armed && !done) begin
      if (!m_mode) begin
        chk(!rst_n ? "R5" : (note != "" ? note : "R2"), "out_hi", out_hi, m_hi);
        chk(!rst_n ? "R5" : "R3", "out_lo", out_lo, m_lo);
        chk("R4", "err", err, 1'b0);
      end else begin
        bit complete, bad, eh, el;
        string tag;
        complete = 1'b1;
        bad = 1'b0;
        for (int k = 0; k < N; k++) begin
          if (rail_t[k] == rail_f[k]) complete = 1'b0;
          if (rail_t[k] && rail_f[k]) bad = 1'b1;
        end
        if (bad)            tag = "R9";
        else if (pre)       tag = "R7";
        else if (!complete) tag = "R8";
        else                tag = "R6";
        if (pre || !complete) begin
          eh = 1'b0; el = 1'b0;
        end else begin
          eh = cfg_hi[int'(rail_t)];
          el = !eh;
        end
        chk(tag, "rail_t_out", out_hi, eh);
        chk(tag, "rail_f_out", out_lo, el);
        chk("R9", "err", err, bad);
        chk("R10", "double_high", out_hi & out_lo, 1'b0);
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // clocked-mode reset, outputs checked under reset (R5)
    rst_n = 1'b0; mode_cfg = 1'b0; cfg_hi = 4'hF; cfg_lo = 4'hF;
    repeat (3) step();
    rst_n = 1'b1;

    // clocked mode patterns (R2, R3, R4), mode pin toggled mid-run (R1)
    for (int i = 0; i < 64; i++) begin
      cfg_hi = T'(i * 7 + 3);
      cfg_lo = T'(i * 11 + 5);
      rail_t = N'(i);
      rail_f = N'(i >> 2);
      pre    = (i % 3) == 0;
      if (i == 20) begin
        mode_cfg = 1'b1;
        note = "R1";
      end
      step();
    end
    note = "";

    // switch to dual-rail through reset
    rst_n = 1'b0; mode_cfg = 1'b1;
    repeat (2) step();
    rst_n = 1'b1;
    mode_cfg = 1'b0; // must be ignored (R1)

    // exhaustive dual-rail sweep (R6, R7, R8, R9, R10)
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int p = 0; p < 2; p++) begin
          cfg_hi = T'(c);
          cfg_lo = T'(a * 5 + c);
          rail_t = N'(a);
          rail_f = N'(a >> 2);
          pre    = p[0];
          step();
        end
      end
    end

    // back to clocked mode: reset clears outputs (R5)
    rst_n = 1'b0; mode_cfg = 1'b0; cfg_hi = 4'hF; cfg_lo = 4'hF;
    rail_t = '0; rail_f = '0; pre = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    @(negedge clk);
    #1;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule